// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This controller decides which power state a small system-on-chip is in and drives the signals that put the rest of the chip into that state. It has three architectural states: Operating (everything clocked), Idle (only the processor clock stopped) and Standby (main oscillator off, buses parked low, peripherals held in reset). Two further states handle the transitions. SrWait requests DRAM self-refresh and waits for the acknowledge before the oscillator is switched off. Settle waits a programmable number of cycles for the restarted oscillator to become stable before the clocks are enabled and the resets are released. The controller runs from an always-on clock.

An active-low power-on reset is the only asynchronous reset. It puts the controller in Standby and sets a sticky cold flag. While the flag is set, only a rising edge on the external wake pin can leave Standby. The flag clears when Operating is first reached. After that, a Standby entered by software can be left either by a wake-pin edge or by any interrupt request that is already masked. Software asks for Idle or Standby with single-cycle request strobes.

The states and their transitions are:
- Standby→Settle on a wake event.
- Settle→Operating when the settle count completes.
- Operating→SrWait, or Operating→Standby, on a standby request. SrWait is taken when refresh is enabled.
- Operating→Idle on an idle request.
- Idle→Operating on an interrupt.
- SrWait→Standby on the self-refresh acknowledge.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While por_n is low and on its release, the outputs are: run=0, osc_en=0, core_clk_en=0, cpu_clk_en=0, sr_req=0, bus_park=1, all periph_rst_n bits 0 (reset asserted) and cold_flag=1. por_n also takes effect asynchronously from any state.
- R2: While cold_flag is 1 and the controller is in Standby, interrupt requests have no effect and run stays 0.
- R3: A 0→1 transition on wakeup_pin passes through two synchroniser flops and an edge detector. It moves Standby to Settle, and run is 1 after the third rising clock edge after the pin rises. A pin that is held high does not produce a second wake.
- R4: Settle lasts settle_cycles+1 clock cycles. In it, run=1, osc_en=1, core_clk_en=0, bus_park=1 and the peripheral resets stay asserted. The following state is Operating, in which run, osc_en, core_clk_en and cpu_clk_en are 1, bus_park is 0, every periph_rst_n bit is 1 and cold_flag is 0.
- R5: After Standby is entered by software, any set bit of irq_req moves Standby to Settle on the next clock edge.
- R6: After Standby is entered by software, a wakeup_pin rising edge also leaves Standby.
- R7: A standby request with refresh_en=0 reaches Standby on the next edge, with sr_req held 0.
- R8: A standby request with refresh_en=1 first raises sr_req while osc_en stays 1, and keeps it so until sr_ack is 1. Standby (osc_en=0) follows on the next edge. sr_req stays 1 through Standby and Settle and drops on entry to Operating.
- R9: An idle request in Operating gives cpu_clk_en=0 with run, osc_en and core_clk_en still 1. A wakeup_pin edge in Idle has no effect. Any irq_req bit returns the controller to Operating on the next edge.
- R10: When sw_stby_req and sw_idle_req are both 1 in Operating, Standby is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wakeup_pin | input | 1 | External wake pin, asynchronous |
| sw_idle_req | input | 1 | Software strobe to enter Idle |
| sw_stby_req | input | 1 | Software strobe to enter Standby |
| refresh_en | input | 1 | DRAM refresh enabled; Standby entry goes through self-refresh |
| sr_ack | input | 1 | DRAM controller acknowledges self-refresh |
| irq_req | input | NUM_IRQ | Masked interrupt requests |
| settle_cycles | input | SETTLE_W | Oscillator settle count; Settle lasts this value plus one cycles |
| run | output | 1 | Low only in Standby |
| osc_en | output | 1 | Main oscillator/PLL enable |
| core_clk_en | output | 1 | Core clock enable |
| cpu_clk_en | output | 1 | Processor clock enable |
| sr_req | output | 1 | DRAM self-refresh request |
| bus_park | output | 1 | Forces external address and data buses low |
| periph_rst_n | output | NUM_PERIPH | Per-peripheral reset, active low |
| cold_flag | output | 1 | Sticky cold-reset indicator |

## Verification
The bench builds the controller with NUM_IRQ=4, NUM_PERIPH=5 and SETTLE_W=6. With a six-bit count, a settle length of 1 cycle (count 0) and of 11 cycles (count 10) can both be measured cycle by cycle. Four interrupt lines let each wake case use a different single bit. Five peripheral resets are few enough to compare as a whole word against all-zero and all-one.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_STBY   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_OPER   = 3'd2,
        ST_IDLE   = 3'd3,
        ST_SRWAIT = 3'd4
    } pwr_state_e;

endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic pulse
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= pin;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    assign pulse = sync_q[LAST] & ~prev_q;

    // R3: an edge yields exactly one pulse cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (!active) cnt_q <= '0;
        else if (!done)   cnt_q <= cnt_q + 1'b1;
    end

    assign done = active && (cnt_q == limit);

    // R4: count restarts from zero on each settle entry
    a_r4_count_starts_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> cnt_q == '0);

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int NUM_IRQ    = 8,
    parameter int NUM_PERIPH = 6,
    parameter int SETTLE_W   = 10
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  wakeup_pin,
    input  logic                  sw_idle_req,
    input  logic                  sw_stby_req,
    input  logic                  refresh_en,
    input  logic                  sr_ack,
    input  logic [NUM_IRQ-1:0]    irq_req,
    input  logic [SETTLE_W-1:0]   settle_cycles,
    output logic                  run,
    output logic                  osc_en,
    output logic                  core_clk_en,
    output logic                  cpu_clk_en,
    output logic                  sr_req,
    output logic                  bus_park,
    output logic [NUM_PERIPH-1:0] periph_rst_n,
    output logic                  cold_flag
);
    localparam int SYNC_STAGES = 2;

    pwr_state_e state_q, state_d;
    logic       cold_q;
    logic       sr_hold_q;
    logic       wake_pulse;
    logic       settle_done;
    logic       irq_any;
    logic       stby_wake;

    assign irq_any   = |irq_req;
    assign stby_wake = wake_pulse || (!cold_q && irq_any);

    pwr_wake_sync #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
        .clk   (clk),
        .rst_n (por_n),
        .pin   (wakeup_pin),
        .pulse (wake_pulse)
    );

    pwr_settle_timer #(.CNT_W(SETTLE_W)) u_settle (
        .clk    (clk),
        .rst_n  (por_n),
        .active (state_q == ST_SETTLE),
        .limit  (settle_cycles),
        .done   (settle_done)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STBY:   if (stby_wake) state_d = ST_SETTLE;
            ST_SETTLE: if (settle_done) state_d = ST_OPER;
            ST_OPER: begin
                if (sw_stby_req)      state_d = refresh_en ? ST_SRWAIT : ST_STBY;
                else if (sw_idle_req) state_d = ST_IDLE;
            end
            ST_IDLE:   if (irq_any) state_d = ST_OPER;
            ST_SRWAIT: if (sr_ack) state_d = ST_STBY;
            default:   state_d = ST_STBY;
        endcase
    end

    // state, cold flag and refresh hold registers
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q   <= ST_STBY;
            cold_q    <= 1'b1;
            sr_hold_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_OPER) begin
                cold_q    <= 1'b0;
                sr_hold_q <= 1'b0;
            end else if (state_d == ST_SRWAIT) begin
                sr_hold_q <= 1'b1;
            end
        end
    end

    // output decode
    always_comb begin
        run          = 1'b0;
        osc_en       = 1'b0;
        core_clk_en  = 1'b0;
        cpu_clk_en   = 1'b0;
        bus_park     = 1'b1;
        periph_rst_n = '0;
        unique case (state_q)
            ST_STBY: ;
            ST_SETTLE: begin
                run    = 1'b1;
                osc_en = 1'b1;
            end
            ST_OPER: begin
                run          = 1'b1;
                osc_en       = 1'b1;
                core_clk_en  = 1'b1;
                cpu_clk_en   = 1'b1;
                bus_park     = 1'b0;
                periph_rst_n = '1;
            end
            ST_IDLE, ST_SRWAIT: begin
                run          = 1'b1;
                osc_en       = 1'b1;
                core_clk_en  = 1'b1;
                bus_park     = 1'b0;
                periph_rst_n = '1;
            end
            default: ;
        endcase
    end

    assign sr_req    = sr_hold_q;
    assign cold_flag = cold_q;

    // R2: while cold, only a pin edge leaves standby
    a_r2_cold_ignores_irq: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_STBY && cold_q && !wake_pulse) |=> state_q == ST_STBY);

    // R4: clocks start only when the settle count has expired
    a_r4_clk_after_settle: assert property (@(posedge clk) disable iff (!por_n)
        $rose(core_clk_en) |-> $past(settle_done));

    // R4: operating implies the cold flag was cleared
    a_r4_oper_not_cold: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_OPER) |-> !cold_q);

    // R7: no self-refresh when refresh is disabled
    a_r7_direct_standby: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_OPER && sw_stby_req && !refresh_en) |=> (state_q == ST_STBY && !sr_req));

    // R8: oscillator stops with refresh active only after acknowledge
    a_r8_osc_after_ack: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(osc_en) && sr_req) |-> $past(sr_ack));

    // R9: idle is held until an interrupt arrives
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_IDLE && !irq_any) |=> state_q == ST_IDLE);

endmodule

// File: tb/pwr_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_tb_top;
    localparam int NIRQ = 4;
    localparam int NPER = 5;
    localparam int SW   = 6;

    logic            clk = 1'b0;
    logic            por_n = 1'b0;
    logic            wakeup_pin = 1'b0;
    logic            sw_idle_req = 1'b0;
    logic            sw_stby_req = 1'b0;
    logic            refresh_en = 1'b0;
    logic            sr_ack = 1'b0;
    logic [NIRQ-1:0] irq_req = '0;
    logic [SW-1:0]   settle_cycles = 6'd3;
    logic            run, osc_en, core_clk_en, cpu_clk_en, sr_req, bus_park, cold_flag;
    logic [NPER-1:0] periph_rst_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    pwr_seq_ctrl #(.NUM_IRQ(NIRQ), .NUM_PERIPH(NPER), .SETTLE_W(SW)) dut_i (
        .clk(clk), .por_n(por_n), .wakeup_pin(wakeup_pin),
        .sw_idle_req(sw_idle_req), .sw_stby_req(sw_stby_req),
        .refresh_en(refresh_en), .sr_ack(sr_ack), .irq_req(irq_req),
        .settle_cycles(settle_cycles), .run(run), .osc_en(osc_en),
        .core_clk_en(core_clk_en), .cpu_clk_en(cpu_clk_en), .sr_req(sr_req),
        .bus_park(bus_park), .periph_rst_n(periph_rst_n), .cold_flag(cold_flag)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_standby(input string req);
        chk(run == 0 && osc_en == 0 && core_clk_en == 0 && cpu_clk_en == 0,
            req, "standby enables", int'({run, osc_en, core_clk_en, cpu_clk_en}), 0);
        chk(bus_park == 1 && periph_rst_n == '0, req, "standby park/reset",
            int'({bus_park, periph_rst_n}), 32);
    endtask

    task automatic chk_oper(input string req);
        chk(run && osc_en && core_clk_en && cpu_clk_en && !bus_park && periph_rst_n == '1,
            req, "operating outputs",
            int'({run, osc_en, core_clk_en, cpu_clk_en, bus_park, periph_rst_n}), 991);
    endtask

    // measure settle length; first sample already taken inside Settle
    task automatic measure_settle(input string req, input int exp);
        int n = 0;
        while (!core_clk_en && n < 200) begin
            if (!(run && osc_en && bus_park && periph_rst_n == '0)) begin
                chk(0, req, "settle outputs", int'({run, osc_en, bus_park}), 7);
            end
            n++;
            tick();
        end
        chk(n == exp, req, "settle length", n, exp);
    endtask

    task automatic t_reset();
        tick(2);
        chk_standby("R1");
        chk(cold_flag == 1 && sr_req == 0, "R1", "cold/sr after reset",
            int'({cold_flag, sr_req}), 2);
        por_n = 1'b1;
        tick(2);
        chk_standby("R1");
    endtask

    task automatic t_cold_irq_ignored();
        irq_req = 4'b0010;
        tick(20);
        chk(run == 0, "R2", "run while cold with irq", int'(run), 0);
        irq_req = '0;
    endtask

    task automatic t_cold_pin_wake();
        settle_cycles = 6'd3;
        wakeup_pin = 1'b1;
        tick(2);
        chk(run == 0, "R3", "run before third edge", int'(run), 0);
        tick();
        chk(run == 1, "R3", "run after third edge", int'(run), 1);
        measure_settle("R4", 4);
        chk_oper("R4");
        chk(cold_flag == 0, "R4", "cold flag in operating", int'(cold_flag), 0);
        tick(6);
        chk_oper("R3");   // held pin: no re-trigger
        wakeup_pin = 1'b0;
        tick(3);
    endtask

    task automatic t_stby_irq_wake();
        refresh_en = 1'b0;
        settle_cycles = 6'd0;
        sw_stby_req = 1'b1;
        tick();
        sw_stby_req = 1'b0;
        chk_standby("R7");
        chk(sr_req == 0, "R7", "sr_req without refresh", int'(sr_req), 0);
        tick(3);
        irq_req = 4'b0100;
        tick();
        irq_req = '0;
        chk(run == 1 && core_clk_en == 0, "R5", "irq warm wake into settle",
            int'({run, core_clk_en}), 2);
        measure_settle("R4", 1);
        chk_oper("R5");
    endtask

    task automatic t_stby_refresh_pin_wake();
        refresh_en = 1'b1;
        settle_cycles = 6'd10;
        sw_stby_req = 1'b1;
        tick();
        sw_stby_req = 1'b0;
        chk(sr_req == 1 && osc_en == 1 && run == 1, "R8", "self-refresh request",
            int'({sr_req, osc_en, run}), 7);
        tick(4);
        chk(osc_en == 1 && sr_req == 1, "R8", "osc held until ack",
            int'({osc_en, sr_req}), 3);
        sr_ack = 1'b1;
        tick();
        sr_ack = 1'b0;
        chk_standby("R8");
        chk(sr_req == 1, "R8", "sr_req held in standby", int'(sr_req), 1);
        tick(3);
        wakeup_pin = 1'b1;
        tick(3);
        chk(run == 1 && sr_req == 1, "R6", "pin warm wake, sr still held",
            int'({run, sr_req}), 3);
        measure_settle("R4", 11);
        chk_oper("R6");
        chk(sr_req == 0, "R8", "sr_req dropped in operating", int'(sr_req), 0);
        wakeup_pin = 1'b0;
        refresh_en = 1'b0;
        tick(3);
    endtask

    task automatic t_idle();
        sw_idle_req = 1'b1;
        tick();
        sw_idle_req = 1'b0;
        chk(cpu_clk_en == 0 && core_clk_en == 1 && run == 1 && osc_en == 1, "R9",
            "idle outputs", int'({cpu_clk_en, core_clk_en, run, osc_en}), 7);
        wakeup_pin = 1'b1;
        tick(6);
        chk(cpu_clk_en == 0, "R9", "pin edge ignored in idle", int'(cpu_clk_en), 0);
        wakeup_pin = 1'b0;
        tick(3);
        irq_req = 4'b1000;
        tick();
        irq_req = '0;
        chk_oper("R9");
    endtask

    task automatic t_priority();
        settle_cycles = 6'd2;
        sw_idle_req = 1'b1;
        sw_stby_req = 1'b1;
        tick();
        sw_idle_req = 1'b0;
        sw_stby_req = 1'b0;
        chk(run == 0, "R10", "standby wins over idle", int'(run), 0);
        irq_req = 4'b0001;
        tick();
        irq_req = '0;
        measure_settle("R4", 3);
        chk_oper("R10");
    endtask

    task automatic t_por_async();
        #2 por_n = 1'b0;
        #1;
        chk_standby("R1");
        chk(cold_flag == 1, "R1", "cold flag after async reset", int'(cold_flag), 1);
        tick();
        por_n = 1'b1;
        tick(2);
        chk_standby("R1");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_cold_irq_ignored();
        t_cold_pin_wake();
        t_stby_irq_wake();
        t_stby_refresh_pin_wake();
        t_idle();
        t_priority();
        t_por_async();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule